// File: doc/BRIEF.md
# Smart-Card Answer-to-Reset and Speed-Negotiation Tracker

This block listens passively to the bytes received on a half-duplex smart-card line. It does not transmit, and it does not check or compute checksums. The block first follows the card's answer-to-reset. That sequence is a fixed lead byte, a format byte, a chain of optional interface bytes, the historical bytes and an optional check byte. The block then follows the speed-negotiation exchange that comes after it: a request from the reader, and the card's answer to that request.

The block decides which optional bytes are present from the presence bits it has stored. Bytes it is told are absent are skipped, and skipping one takes a single clock cycle. If a header byte breaks the expected shape, the block stops for good in a terminal state.

When the card's answer accepts a speed change, the block stores the two-bit speed multiplier and raises a one-cycle switch strobe on the closing check byte. The surrounding logic uses that strobe to change the line's bit rate.

Top module: `atr_pps_tracker`

## Requirements
- R1: While `card_rst_n` is low, the block is held in its initial state with `done` = 0, `speed_switch` = 0 and `speed_mult` = 0.
- R2: The first received byte after reset must be 8'h3B. Any other value sets `done`, and no strobe is produced.
- R3: In the format byte, bits [7:4] are loaded as the presence mask and bits [3:0] as the historical-byte count. In the mask, bit 0 marks TA, bit 1 TB, bit 2 TC and bit 3 TD.
- R4: A TA, TB or TC byte whose mask bit is 1 consumes exactly one received byte. When its mask bit is 0, it is skipped without consuming a byte.
- R5: A present TD byte loads the mask from its bits [7:4], and parsing restarts at TA. When TD is absent, parsing moves on to the historical bytes.
- R6: If any received TD byte has a non-zero bits [3:0], exactly one check byte is consumed after the historical bytes. Otherwise no check byte is consumed.
- R7: Exactly as many historical bytes are consumed as the count loaded in R3.
- R8: The speed request and the card's answer must each start with 8'hFF. Any other value sets `done`, and no strobe is produced.
- R9: In the request's PPS0 byte, bits 4, 5 and 6 mark the presence of PPS1, PPS2 and PPS3. Each present byte consumes one received byte, and each absent byte is skipped. One request check byte of any value then follows.
- R10: If the answer's PPS0 byte has bit 4 clear, `done` is set and no strobe is produced. Otherwise its bits 6:4 replace the stored presence bits.
- R11: The answer's PPS1 byte must have bits [7:2] equal to 6'b100101, otherwise `done` is set. When they match, `speed_mult` takes bits [1:0] of that byte.
- R12: The answer's check byte raises `speed_switch` for exactly one cycle, starting on the clock edge that samples it, and `done` rises on the same edge.
- R13: Once `done` is set it stays set, and `speed_mult` stays unchanged until the next reset. Later bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| card_rst_n | input | 1 | Card reset, active low, asynchronous |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| speed_mult | output | 2 | Stored speed multiplier bits |
| speed_switch | output | 1 | One-cycle strobe that requests the speed change |
| done | output | 1 | Terminal state reached |

## Verification
The assertions assume that each `rx_valid` pulse lasts one cycle. They also assume that pulses are spaced widely enough for any run of skipped optional bytes to finish. The longest such run is six cycles, going from a TD byte through absent TA, TB, TC and TD, an empty historical field and an absent check byte. A byte that arrives during a skip cycle is dropped, so the sequence would lose alignment. The stimulus therefore follows every byte with eight idle cycles, and it holds reset low across several clock edges.

// File: rtl/atr_pps_tracker.sv
module atr_pps_tracker #(
  parameter logic [7:0] LEAD_BYTE = 8'h3B,
  parameter logic [7:0] NEG_START = 8'hFF,
  parameter logic [5:0] ANS_TAG   = 6'b100101
) (
  input  logic       clk,
  input  logic       card_rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [1:0] speed_mult,
  output logic       speed_switch,
  output logic       done
);

  typedef enum logic [4:0] {
    ST_LEAD, ST_FMT, ST_IA, ST_IB, ST_IC, ST_ID, ST_HIST, ST_CHK,
    ST_RQ_HDR, ST_RQ_P0, ST_RQ_P1, ST_RQ_P2, ST_RQ_P3, ST_RQ_CHK,
    ST_AN_HDR, ST_AN_P0, ST_AN_P1, ST_AN_P2, ST_AN_P3, ST_AN_CHK,
    ST_END
  } state_t;

  state_t     st;
  logic [3:0] pres;
  logic [3:0] hist_left;
  logic       chk_due;
  logic [2:0] neg_pres;
  logic [1:0] mult_q;
  logic       sw_q;

  assign speed_mult   = mult_q;
  assign speed_switch = sw_q;
  assign done         = (st == ST_END);

  always_ff @(posedge clk or negedge card_rst_n) begin
    if (!card_rst_n) begin
      st        <= ST_LEAD;
      pres      <= '0;
      hist_left <= '0;
      chk_due   <= 1'b0;
      neg_pres  <= '0;
      mult_q    <= '0;
      sw_q      <= 1'b0;
    end else begin
      sw_q <= 1'b0;
      case (st)
        ST_LEAD:
          if (rx_valid) st <= (rx_byte == LEAD_BYTE) ? ST_FMT : ST_END;
        ST_FMT:
          if (rx_valid) begin
            pres      <= rx_byte[7:4];
            hist_left <= rx_byte[3:0];
            st        <= ST_IA;
          end
        ST_IA: if (!pres[0] || rx_valid) st <= ST_IB;
        ST_IB: if (!pres[1] || rx_valid) st <= ST_IC;
        ST_IC: if (!pres[2] || rx_valid) st <= ST_ID;
        ST_ID:
          if (!pres[3]) st <= ST_HIST;
          else if (rx_valid) begin
            pres <= rx_byte[7:4];
            if (rx_byte[3:0] != 4'd0) chk_due <= 1'b1;
            st <= ST_IA;
          end
        ST_HIST:
          if (hist_left == 4'd0) st <= ST_CHK;
          else if (rx_valid) hist_left <= hist_left - 4'd1;
        ST_CHK: if (!chk_due || rx_valid) st <= ST_RQ_HDR;
        ST_RQ_HDR:
          if (rx_valid) st <= (rx_byte == NEG_START) ? ST_RQ_P0 : ST_END;
        ST_RQ_P0:
          if (rx_valid) begin
            neg_pres <= rx_byte[6:4];
            st       <= ST_RQ_P1;
          end
        ST_RQ_P1: if (!neg_pres[0] || rx_valid) st <= ST_RQ_P2;
        ST_RQ_P2: if (!neg_pres[1] || rx_valid) st <= ST_RQ_P3;
        ST_RQ_P3: if (!neg_pres[2] || rx_valid) st <= ST_RQ_CHK;
        ST_RQ_CHK: if (rx_valid) st <= ST_AN_HDR;
        ST_AN_HDR:
          if (rx_valid) st <= (rx_byte == NEG_START) ? ST_AN_P0 : ST_END;
        ST_AN_P0:
          if (rx_valid) begin
            if (!rx_byte[4]) st <= ST_END;
            else begin
              neg_pres <= rx_byte[6:4];
              st       <= ST_AN_P1;
            end
          end
        ST_AN_P1:
          if (rx_valid) begin
            if (rx_byte[7:2] == ANS_TAG) begin
              mult_q <= rx_byte[1:0];
              st     <= ST_AN_P2;
            end else st <= ST_END;
          end
        ST_AN_P2: if (!neg_pres[1] || rx_valid) st <= ST_AN_P3;
        ST_AN_P3: if (!neg_pres[2] || rx_valid) st <= ST_AN_CHK;
        ST_AN_CHK:
          if (rx_valid) begin
            sw_q <= 1'b1;
            st   <= ST_END;
          end
        ST_END: st <= ST_END;
        default: st <= ST_END;
      endcase
    end
  end

endmodule

// File: rtl/atr_pps_tracker_chk.sv
module atr_pps_tracker_chk (
  input logic       clk,
  input logic       card_rst_n,
  input logic       rx_valid,
  input logic [1:0] speed_mult,
  input logic       speed_switch,
  input logic       done
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !card_rst_n |-> (!done && !speed_switch && speed_mult == 2'd0));

  // R13
  done_sticky_chk: assert property (@(posedge clk) disable iff (!card_rst_n)
    done |=> done);

  // R13
  mult_hold_chk: assert property (@(posedge clk) disable iff (!card_rst_n)
    done |=> $stable(speed_mult));

  // R12
  switch_single_chk: assert property (@(posedge clk) disable iff (!card_rst_n)
    speed_switch |=> !speed_switch);

  // R12
  switch_done_chk: assert property (@(posedge clk) disable iff (!card_rst_n)
    speed_switch |-> done);

  // R12
  switch_byte_chk: assert property (@(posedge clk) disable iff (!card_rst_n)
    speed_switch |-> $past(rx_valid));

  // R11
  mult_byte_chk: assert property (@(posedge clk) disable iff (!card_rst_n)
    !$stable(speed_mult) |-> $past(rx_valid));

endmodule

bind atr_pps_tracker atr_pps_tracker_chk i_chk (
  .clk(clk),
  .card_rst_n(card_rst_n),
  .rx_valid(rx_valid),
  .speed_mult(speed_mult),
  .speed_switch(speed_switch),
  .done(done)
);

// File: tb/test_atr_pps_tracker.sv
`timescale 1ns/1ps
module test_atr_pps_tracker;

  logic       clk = 1'b0;
  logic       card_rst_n;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic [1:0] speed_mult;
  logic       speed_switch;
  logic       done;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  atr_pps_tracker i_atr_pps_tracker (
    .clk(clk), .card_rst_n(card_rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .speed_mult(speed_mult), .speed_switch(speed_switch), .done(done)
  );

  // {byte, done, switch, mult}
  localparam logic [11:0] VEC_A [19] = '{
    12'h3B0, 12'hF20, 12'h110, 12'h220, 12'h330, 12'h110, 12'h960,
    12'h410, 12'h420, 12'h5A0, 12'hFF0, 12'h100, 12'h960, 12'h790,
    12'hFF0, 12'h100, 12'h962, 12'h79E, 12'hEEA
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic ed, input logic es, input logic [1:0] em);
    check(req, "done", int'(done), int'(ed));
    check(req, "speed_switch", int'(speed_switch), int'(es));
    check(req, "speed_mult", int'(speed_mult), int'(em));
  endtask

  task automatic send(input logic [7:0] b, input logic ed, input logic es,
                      input logic [1:0] em, input string req);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte  = 8'h00;
    outs(req, ed, es, em);
    if (es) begin
      @(negedge clk);
      check("R12", "switch width", int'(speed_switch), 0);
      check("R12", "done after switch", int'(done), 1);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    card_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    outs("R1", 1'b0, 1'b0, 2'd0);
    card_rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    card_rst_n = 1'b0;
    rx_valid   = 1'b0;
    rx_byte    = 8'h00;
    @(negedge clk);
    do_reset();

    for (int i = 0; i < 19; i++)
      send(VEC_A[i][11:4], VEC_A[i][3], VEC_A[i][2], VEC_A[i][1:0], "R3/R4/R5/R6/R7/R9/R11/R12/R13");

    // R1: reset after a completed run clears everything
    do_reset();

    // R2 bad lead byte, then R13 later bytes ignored
    send(8'h3F, 1'b1, 1'b0, 2'd0, "R2");
    send(8'h3B, 1'b1, 1'b0, 2'd0, "R13");
    send(8'h00, 1'b1, 1'b0, 2'd0, "R13");
    do_reset();

    // R10: answer PPS0 with bit 4 clear
    send(8'h3B, 1'b0, 1'b0, 2'd0, "R10");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R7");
    send(8'hFF, 1'b0, 1'b0, 2'd0, "R6");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R9");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R9");
    send(8'hFF, 1'b0, 1'b0, 2'd0, "R8");
    send(8'h00, 1'b1, 1'b0, 2'd0, "R10");
    do_reset();

    // R5/R4/R6: TD-only format, TD without check flag, full request, partial answer
    send(8'h3B, 1'b0, 1'b0, 2'd0, "R5");
    send(8'h80, 1'b0, 1'b0, 2'd0, "R5");
    send(8'h70, 1'b0, 1'b0, 2'd0, "R5");
    send(8'h01, 1'b0, 1'b0, 2'd0, "R4");
    send(8'h02, 1'b0, 1'b0, 2'd0, "R4");
    send(8'h03, 1'b0, 1'b0, 2'd0, "R4");
    send(8'hFF, 1'b0, 1'b0, 2'd0, "R6");
    send(8'h70, 1'b0, 1'b0, 2'd0, "R9");
    send(8'h0A, 1'b0, 1'b0, 2'd0, "R9");
    send(8'h0B, 1'b0, 1'b0, 2'd0, "R9");
    send(8'h0C, 1'b0, 1'b0, 2'd0, "R9");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R9");
    send(8'hFF, 1'b0, 1'b0, 2'd0, "R8");
    send(8'h30, 1'b0, 1'b0, 2'd0, "R10");
    send(8'h97, 1'b0, 1'b0, 2'd3, "R11");
    send(8'h0D, 1'b0, 1'b0, 2'd3, "R10");
    send(8'h44, 1'b1, 1'b1, 2'd3, "R12");
    send(8'hFF, 1'b1, 1'b0, 2'd3, "R13");
    do_reset();

    // R8: request header not 8'hFF
    send(8'h3B, 1'b0, 1'b0, 2'd0, "R8");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R8");
    send(8'hAA, 1'b1, 1'b0, 2'd0, "R8");
    do_reset();

    // R8: answer header not 8'hFF
    send(8'h3B, 1'b0, 1'b0, 2'd0, "R8");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R8");
    send(8'hFF, 1'b0, 1'b0, 2'd0, "R8");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R8");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R8");
    send(8'h55, 1'b1, 1'b0, 2'd0, "R8");
    do_reset();

    // R11: answer PPS1 tag mismatch
    send(8'h3B, 1'b0, 1'b0, 2'd0, "R11");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R11");
    send(8'hFF, 1'b0, 1'b0, 2'd0, "R11");
    send(8'h10, 1'b0, 1'b0, 2'd0, "R11");
    send(8'h96, 1'b0, 1'b0, 2'd0, "R11");
    send(8'h00, 1'b0, 1'b0, 2'd0, "R11");
    send(8'hFF, 1'b0, 1'b0, 2'd0, "R11");
    send(8'h10, 1'b0, 1'b0, 2'd0, "R11");
    send(8'hA5, 1'b1, 1'b0, 2'd0, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule